// File: doc/BRIEF.md
# Hexagon Sector Detector for Space Vector Modulation

This block tells a space vector modulator which of the six 60-degree sectors of the inverter hexagon the voltage reference lies in. It takes the reference as two signed Q1.15 components in the stationary frame, alpha on the real axis and beta on the imaginary axis. It returns a sector code from 1 to 6, where sector k covers angles from (k-1)*60 degrees to k*60 degrees. The on-time stage downstream uses the code to pick its coefficients and its switching order.

The block computes no angle and performs no division. The signs of the two components select the quadrant, and each quadrant is shared by two sectors. One compare then resolves the sector: the magnitude of beta is multiplied by a 1/sqrt(3) constant, the product is rounded, and its upper word is checked against the magnitude of alpha. Magnitudes come from a saturating absolute value, so the code 0x8000 becomes 0x7FFF. The input has a valid/ready handshake. The result is registered and marked by a one-cycle valid pulse.

Top module: `svm_sector_detect`

## Requirements
- R1: Whenever `out_valid` is high, `out_sector` holds a code in the range 1 to 6.
- R2: `out_valid` is high for exactly one cycle, and only in the cycle after an input is accepted. An input is accepted when `in_valid` and `in_ready` are both high at a rising clock edge.
- R3: The sign of beta (bit 15) alone picks the half plane. Beta with bit 15 clear gives a sector in 1..3. Beta with bit 15 set gives a sector in 4..6.
- R4: With alpha and beta both non-negative, the result is 2 if the scaled |beta| is greater than alpha, and 1 otherwise.
- R5: With alpha negative and beta non-negative, the result is 2 if the scaled |beta| is greater than |alpha|, and 3 otherwise.
- R6: With alpha non-negative and beta negative, the result is 5 if the scaled |beta| is greater than alpha, and 6 otherwise.
- R7: With alpha and beta both negative, the result is 5 if the scaled |beta| is greater than |alpha|, and 4 otherwise.
- R8: The absolute value of 0x8000 saturates to 0x7FFF. For both components, 0x8000 behaves exactly like 0x8001.
- R9: Scaled |beta| equals (|beta|*18919 + 16384) >> 15. This is the rounded upper word of the Q1.15 product with 1/sqrt(3). For example, beta=3 scales to 2.
- R10: When scaled |beta| equals |alpha|, the compare is strictly greater-than and fails. The result is then sector 1, 3, 6 or 4, depending on the quadrant.
- R11: While reset is asserted, `out_valid` and `in_ready` are low. `in_ready` rises within a few cycles after reset is released.
- R12: `out_sector` keeps its value in every cycle that follows a cycle with no accepted input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Reference components are presented |
| in_ready | output | 1 | Block accepts a reference at this edge |
| in_alpha | input | 16 | Real component, signed Q1.15 |
| in_beta | input | 16 | Imaginary component, signed Q1.15 |
| out_valid | output | 1 | One-cycle strobe marking a new sector code |
| out_sector | output | 3 | Sector code 1..6 |

## Verification
In the same clock edge, the block can register a new reference and present the previous result. Back-to-back accepted inputs provoke this. The bench presents a stream of references, some with `in_valid` held high for many consecutive cycles and others with random gaps. At each falling edge it compares `out_valid` and `out_sector` against the reference it drove one edge earlier. The expected value is computed by a bench model of the sign and compare rules. After every gap, the bench also checks that the sector held its previous value.

// File: rtl/svm_sector_pkg.sv
package svm_sector_pkg;
  localparam int unsigned COMP_W   = 16;
  localparam int unsigned FRAC_W   = COMP_W - 1;
  localparam int unsigned INV_SQRT3_Q15 = 18919;
  localparam int unsigned SECTOR_W = 3;

  typedef enum logic [SECTOR_W-1:0] {
    SEC_NONE = 3'd0,
    SEC_1    = 3'd1,
    SEC_2    = 3'd2,
    SEC_3    = 3'd3,
    SEC_4    = 3'd4,
    SEC_5    = 3'd5,
    SEC_6    = 3'd6
  } sector_e;
endpackage

// File: rtl/svm_rst_release.sv
module svm_rst_release #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/svm_sat_abs.sv
module svm_sat_abs #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] value_i,
  output logic [W-1:0] mag_o
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  always_comb begin
    if (value_i == MOST_NEG)   mag_o = MOST_POS;
    else if (value_i[W-1])     mag_o = ~value_i + {{(W-1){1'b0}}, 1'b1};
    else                       mag_o = value_i;
  end

  // R8: magnitude never reaches the sign bit
  always_comb begin
    p_mag_positive_r8: assert (mag_o[W-1] == 1'b0);
  end
endmodule

// File: rtl/svm_inv_sqrt3_scale.sv
module svm_inv_sqrt3_scale #(
  parameter int unsigned W    = 16,
  parameter int unsigned COEF = 18919
) (
  input  logic [W-1:0] mag_i,
  output logic [W-1:0] scaled_o
);
  localparam int unsigned FRAC = W - 1;
  localparam int unsigned PW   = 2 * W;
  localparam logic [PW-1:0] COEF_P = PW'(COEF);
  localparam logic [PW-1:0] HALF_P = PW'(1) << (FRAC - 1);

  logic [PW-1:0] product;
  logic [PW-1:0] rounded;
  logic [PW-1:0] shifted;

  always_comb begin
    product  = {{W{1'b0}}, mag_i} * COEF_P;
    rounded  = product + HALF_P;
    shifted  = rounded >> FRAC;
    scaled_o = shifted[W-1:0];
  end

  // R9: the rounded upper word fits the compare width and never exceeds its input
  always_comb begin
    p_no_spill_r9: assert (shifted[PW-1:W] == '0);
    p_scale_bound_r9: assert (scaled_o <= mag_i);
  end
endmodule

// File: rtl/svm_sector_resolve.sv
module svm_sector_resolve
  import svm_sector_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         alpha_neg_i,
  input  logic         beta_neg_i,
  input  logic [W-1:0] alpha_mag_i,
  input  logic [W-1:0] beta_scaled_i,
  output sector_e      sector_o
);
  logic steep;

  always_comb begin
    steep = beta_scaled_i > alpha_mag_i;
    unique case ({beta_neg_i, alpha_neg_i})
      2'b00:   sector_o = steep ? SEC_2 : SEC_1;
      2'b01:   sector_o = steep ? SEC_2 : SEC_3;
      2'b10:   sector_o = steep ? SEC_5 : SEC_6;
      default: sector_o = steep ? SEC_5 : SEC_4;
    endcase
  end
endmodule

// File: rtl/svm_sector_detect.sv
module svm_sector_detect
  import svm_sector_pkg::*;
#(
  parameter int unsigned W    = COMP_W,
  parameter int unsigned COEF = INV_SQRT3_Q15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [W-1:0]        in_alpha,
  input  logic [W-1:0]        in_beta,
  output logic                out_valid,
  output logic [SECTOR_W-1:0] out_sector
);
  logic          rst_sync_n;
  logic [W-1:0]  alpha_mag;
  logic [W-1:0]  beta_mag;
  logic [W-1:0]  beta_scaled;
  sector_e       sector_now;

  logic          ready_q, ready_d;
  logic          valid_q, valid_d;
  sector_e       sector_q, sector_d;
  logic          accept;

  svm_rst_release #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  svm_sat_abs #(.W(W)) u_abs_alpha (
    .value_i (in_alpha),
    .mag_o   (alpha_mag)
  );

  svm_sat_abs #(.W(W)) u_abs_beta (
    .value_i (in_beta),
    .mag_o   (beta_mag)
  );

  svm_inv_sqrt3_scale #(.W(W), .COEF(COEF)) u_scale (
    .mag_i    (beta_mag),
    .scaled_o (beta_scaled)
  );

  svm_sector_resolve #(.W(W)) u_resolve (
    .alpha_neg_i   (in_alpha[W-1]),
    .beta_neg_i    (in_beta[W-1]),
    .alpha_mag_i   (alpha_mag),
    .beta_scaled_i (beta_scaled),
    .sector_o      (sector_now)
  );

  always_comb begin
    accept   = in_valid & ready_q;
    ready_d  = 1'b1;
    valid_d  = accept;
    sector_d = accept ? sector_now : sector_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ready_q  <= 1'b0;
      valid_q  <= 1'b0;
      sector_q <= SEC_NONE;
    end else begin
      ready_q  <= ready_d;
      valid_q  <= valid_d;
      sector_q <= sector_d;
    end
  end

  assign in_ready   = ready_q;
  assign out_valid  = valid_q;
  assign out_sector = sector_q;

  p_sector_range_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (out_sector >= 3'd1 && out_sector <= 3'd6));

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid == $past(in_valid && in_ready));

  p_half_plane_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> ((out_sector <= 3'd3) == !$past(in_beta[W-1])));

  p_quad_first_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !$past(in_alpha[W-1]) && !$past(in_beta[W-1]))
      |-> (out_sector == 3'd1 || out_sector == 3'd2));

  p_quad_second_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && $past(in_alpha[W-1]) && !$past(in_beta[W-1]))
      |-> (out_sector == 3'd2 || out_sector == 3'd3));

  p_quad_fourth_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !$past(in_alpha[W-1]) && $past(in_beta[W-1]))
      |-> (out_sector == 3'd5 || out_sector == 3'd6));

  p_quad_third_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && $past(in_alpha[W-1]) && $past(in_beta[W-1]))
      |-> (out_sector == 3'd4 || out_sector == 3'd5));

  p_hold_idle_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(in_valid && in_ready) |=> $stable(out_sector));
endmodule

// File: tb/test_svm_sector_detect.sv
module test_svm_sector_detect;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_alpha;
  logic [15:0] in_beta;
  logic        out_valid;
  logic [2:0]  out_sector;

  int n_checks = 0;
  int n_fails  = 0;

  logic       pend_valid = 1'b0;
  logic [2:0] pend_sector = 3'd0;
  string      pend_tag = "";
  logic [2:0] last_sector = 3'd0;

  always #2.5 clk = ~clk;

  svm_sector_detect i_svm_sector_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_alpha   (in_alpha),
    .in_beta    (in_beta),
    .out_valid  (out_valid),
    .out_sector (out_sector)
  );

  function automatic int sat_mag(logic [15:0] v);
    int s = $signed(v);
    if (s < 0) s = -s;
    if (s > 32767) s = 32767;
    return s;
  endfunction

  function automatic int scaled_beta(logic [15:0] b);
    return (sat_mag(b) * 18919 + 16384) >>> 15;
  endfunction

  function automatic logic [2:0] model_sector(logic [15:0] a, logic [15:0] b);
    logic steep = scaled_beta(b) > sat_mag(a);
    case ({b[15], a[15]})
      2'b00:   return steep ? 3'd2 : 3'd1;
      2'b01:   return steep ? 3'd2 : 3'd3;
      2'b10:   return steep ? 3'd5 : 3'd6;
      default: return steep ? 3'd5 : 3'd4;
    endcase
  endfunction

  function automatic string quad_tag(logic [15:0] a, logic [15:0] b);
    case ({b[15], a[15]})
      2'b00:   return "R4";
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, int actual, int expected);
    n_checks++;
    if (actual != expected) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  // Drive one cycle at the falling edge, first judging the previous cycle.
  task automatic step(logic v, logic [15:0] a, logic [15:0] b, string tag);
    @(negedge clk);
    check("R2 out_valid", int'(out_valid), int'(pend_valid));
    if (pend_valid) begin
      check({pend_tag, " sector"}, int'(out_sector), int'(pend_sector));
      check("R1 range", int'(out_sector >= 3'd1 && out_sector <= 3'd6), 1);
      last_sector = out_sector;
    end else begin
      check("R12 hold", int'(out_sector), int'(last_sector));
    end
    in_valid = v;
    in_alpha = a;
    in_beta  = b;
    pend_valid  = v & in_ready;
    pend_sector = model_sector(a, b);
    pend_tag    = (tag != "") ? tag : quad_tag(a, b);
  endtask

  initial begin
    int seed_dummy;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_alpha = '0;
    in_beta  = '0;
    seed_dummy = $urandom(32'h5eed_01);
    repeat (4) @(negedge clk);
    check("R11 valid in reset", int'(out_valid), 0);
    check("R11 ready in reset", int'(in_ready), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 ready after reset", int'(in_ready), 1);
    last_sector = out_sector;

    // directed corners
    step(1, 16'h0000, 16'h0000, "R4");
    step(1, 16'd1,    16'd3,    "R9");   // rounding makes 2 > 1
    step(1, 16'd18918, 16'h7FFF, "R10");
    step(1, 16'd18917, 16'h7FFF, "R4");
    step(1, 16'hB61A, 16'h7FFF, "R10");
    step(1, 16'd18918, 16'h8001, "R10");
    step(1, 16'hB61A, 16'h8001, "R10");
    step(1, 16'hB61A, 16'h8000, "R8");
    step(1, 16'hB61B, 16'h8000, "R8");
    step(1, 16'h8000, 16'h0000, "R8");
    step(1, 16'h8000, 16'h8000, "R8");
    step(1, 16'h8000, 16'h7FFF, "R3");
    step(0, 16'h1234, 16'h8765, "R12");
    step(0, 16'h0000, 16'h7FFF, "R12");

    // random stream, long back-to-back runs and random gaps
    for (int i = 0; i < 3000; i++) begin
      logic v = (i < 1000) ? 1'b1 : ($urandom_range(0, 3) != 0);
      step(v, 16'($urandom), 16'($urandom), "");
    end
    step(0, 16'h0000, 16'h0000, "R12");
    step(0, 16'h0000, 16'h0000, "R12");

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule